// File: doc/BRIEF.md
# Flash Program Interlock Controller

This block sequences the programming of a flash array on behalf of a memory controller. Software arms programming through a control register. The first array write that follows is captured into a program latch, which models the page buffer. Software then raises high voltage through a second control register. While the pulse is active, the block holds off array accesses by withholding their acknowledge and freezes everything except the high-voltage enable bit. Register accesses keep completing during the pulse, so software can still end it.

The pulse ends in one of three ways: software clears the enable bit, software writes the stop bit, or a system reset arrives. An optional pulse timer can also end it after a programmable number of clocks. A master reset returns the block to idle from any state. The analog high-voltage source and the cell array are outside the block; the `hv_active_o` level stands in for the high-voltage request.

Top module: `flash_pgm_interlock`

## Requirements
- R1: After the asynchronous reset `rst_ni`, the following are all zero: `pgm_state_o` (idle = 0), `hv_active_o`, `arr_ack_o`, `reg_ack_o`, `ctl1_o`, `ctl2_o` and `pbuf_valid_o`.
- R2: In idle with the arm bit set (`ctl1` bit 0), an array write captures its address and data into the program latch and moves the block to the loaded state (1). In idle with the arm bit clear, an array write leaves the state at idle and captures nothing. In the loaded state, each array write overwrites the latch.
- R3: In the loaded state, a `ctl2` write with bit 0 set and bit 1 clear moves the block to the pulse state (2). This sets `hv_active_o` and `ctl2_o` bit 0. In idle, the same write leaves the state and `ctl2_o` bit 0 at zero.
- R4: In the pulse state, any of the following returns the block to the loaded state and clears `hv_active_o`: a `ctl2` write with bit 0 clear, a `ctl2` write with bit 1 (stop) set, or a `sys_rst_i` pulse.
- R5: In the loaded state, a `ctl1` write with bit 0 clear returns the block to idle and clears `pbuf_valid_o`. A `mst_rst_i` pulse in any state returns the block to idle and clears `ctl1_o`, `ctl2_o` and `pbuf_valid_o`.
- R6: An array request made outside the pulse state is acknowledged on `arr_ack_o` in the next cycle. In the pulse state, an array request gets no acknowledge, and an array write does not change the program latch.
- R7: Every register write is acknowledged on `reg_ack_o` in the next cycle, in every state.
- R8: In the pulse state, a `ctl2` write changes only bit 0; the spare field `ctl2` bits 7:2 keeps its value. A `ctl1` write in the pulse state is ignored entirely.
- R9: When the timer select field `ctl1` bits 3:1 is nonzero, the pulse state lasts exactly `BASE_CLKS << (sel-1)` cycles and then returns to the loaded state by itself. When the field is zero, the pulse state lasts until software or a reset ends it.
- R10: A `sys_rst_i` pulse outside the pulse state changes neither the state nor the program latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mst_rst_i | input | 1 | Synchronous master reset: returns to idle and clears the registers |
| sys_rst_i | input | 1 | Synchronous system reset: ends a pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 selects ctl1, 1 selects ctl2 |
| reg_wdata_i | input | REG_W | Register write data |
| reg_ack_o | output | 1 | Register write acknowledge, one cycle after the strobe |
| arr_req_i | input | 1 | Array access request |
| arr_we_i | input | 1 | Array access is a write |
| arr_addr_i | input | AW | Array address |
| arr_wdata_i | input | DW | Array write data |
| arr_ack_o | output | 1 | Array address acknowledge |
| hv_active_o | output | 1 | High-voltage pulse active |
| pgm_state_o | output | 2 | State: 0 idle, 1 loaded, 2 pulse |
| ctl1_o | output | REG_W | ctl1 contents: bit 0 arm, bits SEL_W:1 timer select |
| ctl2_o | output | REG_W | ctl2 contents: bit 0 high-voltage enable, bit 1 reads 0, bits 7:2 spare |
| pbuf_valid_o | output | 1 | Program latch holds a word |
| pbuf_addr_o | output | AW | Latched program address |
| pbuf_data_o | output | DW | Latched program data |

## Verification
The assertions assume that the reset and strobe inputs are single-cycle pulses sampled on the rising clock edge. They also assume that a master reset takes priority over any write or request in the same cycle. The checks on frozen state during the pulse are disabled in any cycle that carries a master reset. The directed stimulus drives every strobe for exactly one cycle from the falling edge and never overlaps a reset with a register write. Each scenario begins from a known state that it reaches through the block's own ports.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_HV   = 2'd2
  } pgm_state_e;

  localparam logic SEL_CTL1 = 1'b0;
  localparam logic SEL_CTL2 = 1'b1;
endpackage

// File: rtl/flash_pgm_regs.sv
module flash_pgm_regs #(
  parameter int REG_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mst_rst_i,
  input  logic             ctl1_wr_i,
  input  logic             ctl2_wr_i,
  input  logic             hv_lock_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             reg_we_i,
  output logic             ses_o,
  output logic [SEL_W-1:0] clk_sel_o,
  output logic [REG_W-3:0] spare_o,
  output logic             reg_ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ses_o     <= 1'b0;
      clk_sel_o <= '0;
      spare_o   <= '0;
      reg_ack_o <= 1'b0;
    end else begin
      reg_ack_o <= reg_we_i;
      if (mst_rst_i) begin
        ses_o     <= 1'b0;
        clk_sel_o <= '0;
        spare_o   <= '0;
      end else if (!hv_lock_i) begin
        // during the pulse both registers are frozen; ctl2 bit 0 lives in the fsm
        if (ctl1_wr_i) begin
          ses_o     <= wdata_i[0];
          clk_sel_o <= wdata_i[SEL_W:1];
        end
        if (ctl2_wr_i) spare_o <= wdata_i[REG_W-1:2];
      end
    end
  end
endmodule

// File: rtl/flash_pgm_timer.sv
module flash_pgm_timer #(
  parameter int SEL_W     = 3,
  parameter int BASE_CLKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hv_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  output logic             done_o
);
  localparam int MAX_LEN = BASE_CLKS << ((1 << SEL_W) - 2);
  localparam int CNT_W   = $clog2(MAX_LEN) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;
  logic             run;

  assign run    = hv_i && (clk_sel_i != '0);
  assign len    = CNT_W'(BASE_CLKS) << (clk_sel_i - SEL_W'(1));
  assign done_o = run && (cnt_q == len - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (!hv_i) cnt_q <= '0;
    else if (run)  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/flash_pgm_latch.sv
module flash_pgm_latch #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic          clear_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (clear_i) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (capture_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/flash_pgm_fsm.sv
module flash_pgm_fsm
  import flash_pgm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mst_rst_i,
  input  logic       sys_rst_i,
  input  logic       ses_i,
  input  logic       ctl1_wr_i,
  input  logic       ctl2_wr_i,
  input  logic [1:0] wbits_i,
  input  logic       arr_req_i,
  input  logic       arr_we_i,
  input  logic       timer_done_i,
  output pgm_state_e state_o,
  output logic       capture_o,
  output logic       clear_o,
  output logic       arr_ack_o
);
  pgm_state_e state_d;
  logic       arr_wr;
  logic       hv_on_req, hv_off_req;

  assign arr_wr     = arr_req_i && arr_we_i;
  assign hv_on_req  = ctl2_wr_i && wbits_i[0] && !wbits_i[1];
  assign hv_off_req = ctl2_wr_i && (!wbits_i[0] || wbits_i[1]);

  assign capture_o = !mst_rst_i && arr_wr &&
                     ((state_o == ST_IDLE && ses_i) || state_o == ST_LOAD);
  assign clear_o   = mst_rst_i || (state_o == ST_LOAD && ctl1_wr_i && !wbits_i[0]);

  always_comb begin
    state_d = state_o;
    if (mst_rst_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_o)
        ST_IDLE: if (arr_wr && ses_i) state_d = ST_LOAD;
        ST_LOAD: begin
          if (ctl1_wr_i && !wbits_i[0]) state_d = ST_IDLE;
          else if (hv_on_req)           state_d = ST_HV;
        end
        ST_HV: if (sys_rst_i || timer_done_i || hv_off_req) state_d = ST_LOAD;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o   <= ST_IDLE;
      arr_ack_o <= 1'b0;
    end else begin
      state_o   <= state_d;
      arr_ack_o <= arr_req_i && (state_o != ST_HV);
    end
  end
endmodule

// File: rtl/flash_pgm_interlock.sv
module flash_pgm_interlock
  import flash_pgm_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int REG_W     = 8,
  parameter int SEL_W     = 3,
  parameter int BASE_CLKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mst_rst_i,
  input  logic             sys_rst_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic             reg_ack_o,
  input  logic             arr_req_i,
  input  logic             arr_we_i,
  input  logic [AW-1:0]    arr_addr_i,
  input  logic [DW-1:0]    arr_wdata_i,
  output logic             arr_ack_o,
  output logic             hv_active_o,
  output logic [1:0]       pgm_state_o,
  output logic [REG_W-1:0] ctl1_o,
  output logic [REG_W-1:0] ctl2_o,
  output logic             pbuf_valid_o,
  output logic [AW-1:0]    pbuf_addr_o,
  output logic [DW-1:0]    pbuf_data_o
);
  pgm_state_e       state;
  logic             ctl1_wr, ctl2_wr, hv;
  logic             ses;
  logic [SEL_W-1:0] clk_sel;
  logic [REG_W-3:0] spare;
  logic             timer_done, capture, clear;

  assign ctl1_wr = reg_we_i && (reg_sel_i == SEL_CTL1);
  assign ctl2_wr = reg_we_i && (reg_sel_i == SEL_CTL2);
  assign hv      = (state == ST_HV);

  flash_pgm_regs #(.REG_W(REG_W), .SEL_W(SEL_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mst_rst_i (mst_rst_i),
    .ctl1_wr_i (ctl1_wr),
    .ctl2_wr_i (ctl2_wr),
    .hv_lock_i (hv),
    .wdata_i   (reg_wdata_i),
    .reg_we_i  (reg_we_i),
    .ses_o     (ses),
    .clk_sel_o (clk_sel),
    .spare_o   (spare),
    .reg_ack_o (reg_ack_o)
  );

  flash_pgm_timer #(.SEL_W(SEL_W), .BASE_CLKS(BASE_CLKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hv_i      (hv),
    .clk_sel_i (clk_sel),
    .done_o    (timer_done)
  );

  flash_pgm_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mst_rst_i    (mst_rst_i),
    .sys_rst_i    (sys_rst_i),
    .ses_i        (ses),
    .ctl1_wr_i    (ctl1_wr),
    .ctl2_wr_i    (ctl2_wr),
    .wbits_i      (reg_wdata_i[1:0]),
    .arr_req_i    (arr_req_i),
    .arr_we_i     (arr_we_i),
    .timer_done_i (timer_done),
    .state_o      (state),
    .capture_o    (capture),
    .clear_o      (clear),
    .arr_ack_o    (arr_ack_o)
  );

  flash_pgm_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .clear_i   (clear),
    .addr_i    (arr_addr_i),
    .data_i    (arr_wdata_i),
    .valid_o   (pbuf_valid_o),
    .addr_o    (pbuf_addr_o),
    .data_o    (pbuf_data_o)
  );

  assign hv_active_o = hv;
  assign pgm_state_o = state;
  assign ctl1_o      = REG_W'({clk_sel, ses});
  assign ctl2_o      = {spare, 1'b0, hv};
endmodule

// File: rtl/flash_pgm_checker.sv
module flash_pgm_checker #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int REG_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mst_rst_i,
  input logic             sys_rst_i,
  input logic             reg_we_i,
  input logic             reg_sel_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic             reg_ack_o,
  input logic             arr_req_i,
  input logic             arr_ack_o,
  input logic             hv_active_o,
  input logic [1:0]       pgm_state_o,
  input logic [REG_W-1:0] ctl1_o,
  input logic [REG_W-1:0] ctl2_o,
  input logic [DW-1:0]    pbuf_data_o
);
  logic in_hv, in_load;
  assign in_hv   = (pgm_state_o == 2'd2);
  assign in_load = (pgm_state_o == 2'd1);

  a_r6_no_ack_in_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hv && arr_req_i) |=> !arr_ack_o);

  a_r6_ack_outside_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_hv && arr_req_i) |=> arr_ack_o);

  a_r6_latch_frozen_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hv && !mst_rst_i) |=> $stable(pbuf_data_o));

  a_r7_reg_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_ack_o);

  a_r5_master_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_rst_i |=> (pgm_state_o == 2'd0 && ctl1_o == '0 && ctl2_o == '0));

  a_r4_sys_reset_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hv && sys_rst_i && !mst_rst_i) |=> (in_load && !hv_active_o));

  a_r8_spare_frozen_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hv && reg_we_i && reg_sel_i && !mst_rst_i)
      |=> (ctl2_o[REG_W-1:2] == $past(ctl2_o[REG_W-1:2])));

  a_r8_ctl1_frozen_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hv && !mst_rst_i) |=> $stable(ctl1_o));

  a_r9_manual_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hv && ctl1_o[SEL_W:1] == '0 && !mst_rst_i && !sys_rst_i && !reg_we_i)
      |=> in_hv);

  a_r3_enter_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_load && reg_we_i && reg_sel_i && reg_wdata_i[1:0] == 2'b01 && !mst_rst_i)
      |=> (in_hv && hv_active_o && ctl2_o[0]));
endmodule

bind flash_pgm_interlock flash_pgm_checker #(
  .AW(AW), .DW(DW), .REG_W(REG_W), .SEL_W(SEL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mst_rst_i   (mst_rst_i),
  .sys_rst_i   (sys_rst_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_ack_o   (reg_ack_o),
  .arr_req_i   (arr_req_i),
  .arr_ack_o   (arr_ack_o),
  .hv_active_o (hv_active_o),
  .pgm_state_o (pgm_state_o),
  .ctl1_o      (ctl1_o),
  .ctl2_o      (ctl2_o),
  .pbuf_data_o (pbuf_data_o)
);

// File: tb/flash_pgm_interlock_tb.sv
`timescale 1ns/1ps
module flash_pgm_interlock_tb;
  localparam int AW = 16, DW = 32, REG_W = 8, SEL_W = 3, BASE_CLKS = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             mst_rst_i = 1'b0, sys_rst_i = 1'b0;
  logic             reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [REG_W-1:0] reg_wdata_i = '0;
  logic             reg_ack_o;
  logic             arr_req_i = 1'b0, arr_we_i = 1'b0;
  logic [AW-1:0]    arr_addr_i = '0;
  logic [DW-1:0]    arr_wdata_i = '0;
  logic             arr_ack_o, hv_active_o, pbuf_valid_o;
  logic [1:0]       pgm_state_o;
  logic [REG_W-1:0] ctl1_o, ctl2_o;
  logic [AW-1:0]    pbuf_addr_o;
  logic [DW-1:0]    pbuf_data_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  flash_pgm_interlock #(.AW(AW), .DW(DW), .REG_W(REG_W), .SEL_W(SEL_W),
                        .BASE_CLKS(BASE_CLKS)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic wr_reg(input logic sel, input logic [REG_W-1:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
    chk_eq("R7 reg ack", int'(reg_ack_o), 1);
  endtask

  task automatic arr_acc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic exp_ack);
    @(negedge clk_i);
    arr_req_i = 1'b1; arr_we_i = we; arr_addr_i = a; arr_wdata_i = d;
    @(negedge clk_i);
    arr_req_i = 1'b0; arr_we_i = 1'b0;
    chk_eq("R6 array ack", int'(arr_ack_o), int'(exp_ack));
  endtask

  task automatic pulse_mst();
    @(negedge clk_i); mst_rst_i = 1'b1;
    @(negedge clk_i); mst_rst_i = 1'b0;
  endtask

  task automatic pulse_sys();
    @(negedge clk_i); sys_rst_i = 1'b1;
    @(negedge clk_i); sys_rst_i = 1'b0;
  endtask

  // bring the block to the loaded state with the given timer select
  task automatic to_load(input logic [SEL_W-1:0] sel);
    wr_reg(1'b0, REG_W'({sel, 1'b1}));
    arr_acc(1'b1, 16'h0040, 32'h1111_2222, 1'b1);
    chk_eq("R2 loaded", int'(pgm_state_o), 1);
  endtask

  task automatic t_reset();
    chk_eq("R1 state", int'(pgm_state_o), 0);
    chk_eq("R1 hv", int'(hv_active_o), 0);
    chk_eq("R1 acks", int'({arr_ack_o, reg_ack_o}), 0);
    chk_eq("R1 ctl1", int'(ctl1_o), 0);
    chk_eq("R1 ctl2", int'(ctl2_o), 0);
    chk_eq("R1 valid", int'(pbuf_valid_o), 0);
  endtask

  task automatic t_idle_capture();
    arr_acc(1'b1, 16'h0012, 32'hDEAD_0001, 1'b1);
    chk_eq("R2 no arm stays idle", int'(pgm_state_o), 0);
    chk_eq("R2 no arm no capture", int'(pbuf_valid_o), 0);
    wr_reg(1'b1, 8'h01);
    chk_eq("R3 idle ignores hv", int'(ctl2_o[0]), 0);
    chk_eq("R3 idle state", int'(pgm_state_o), 0);
    wr_reg(1'b0, 8'h01);
    chk_eq("R7 ctl1 written", int'(ctl1_o), 8'h01);
    arr_acc(1'b1, 16'h0034, 32'hA5A5_5A5A, 1'b1);
    chk_eq("R2 enter load", int'(pgm_state_o), 1);
    chk_eq("R2 valid", int'(pbuf_valid_o), 1);
    chk_eq("R2 addr", int'(pbuf_addr_o), 16'h0034);
    chk_eq("R2 data", int'(pbuf_data_o), 32'hA5A5_5A5A);
    arr_acc(1'b1, 16'h0035, 32'h0BAD_F00D, 1'b1);
    chk_eq("R2 overwrite data", int'(pbuf_data_o), 32'h0BAD_F00D);
    pulse_sys();
    chk_eq("R10 sys reset load state", int'(pgm_state_o), 1);
    chk_eq("R10 sys reset latch", int'(pbuf_data_o), 32'h0BAD_F00D);
    wr_reg(1'b0, 8'h00);
    chk_eq("R5 disarm to idle", int'(pgm_state_o), 0);
    chk_eq("R5 latch cleared", int'(pbuf_valid_o), 0);
  endtask

  task automatic t_manual_pulse();
    to_load('0);
    wr_reg(1'b1, 8'hA9);
    chk_eq("R3 enter pulse", int'(pgm_state_o), 2);
    chk_eq("R3 hv active", int'(hv_active_o), 1);
    chk_eq("R3 ctl2", int'(ctl2_o), 8'hA9);
    repeat (12) @(negedge clk_i);
    chk_eq("R9 manual hold", int'(pgm_state_o), 2);
    arr_acc(1'b0, 16'h0050, '0, 1'b0);
    arr_acc(1'b1, 16'h0051, 32'h7777_7777, 1'b0);
    chk_eq("R6 no capture", int'(pbuf_data_o), 32'h1111_2222);
    wr_reg(1'b1, 8'h55);
    chk_eq("R8 spare frozen", int'(ctl2_o), 8'hA9);
    wr_reg(1'b0, 8'h00);
    chk_eq("R8 ctl1 ignored", int'(ctl1_o), 8'h01);
    chk_eq("R8 still pulse", int'(pgm_state_o), 2);
    wr_reg(1'b1, 8'h00);
    chk_eq("R4 hv clear exit", int'(pgm_state_o), 1);
    chk_eq("R4 ctl2 after", int'(ctl2_o), 8'hA8);
    wr_reg(1'b1, 8'h01);
    wr_reg(1'b1, 8'h03);
    chk_eq("R4 stop exit", int'(pgm_state_o), 1);
    chk_eq("R4 stop hv low", int'(hv_active_o), 0);
    wr_reg(1'b1, 8'h01);
    pulse_sys();
    chk_eq("R4 sys reset exit", int'(pgm_state_o), 1);
    arr_acc(1'b0, 16'h0052, '0, 1'b1);
    wr_reg(1'b1, 8'h01);
    pulse_mst();
    chk_eq("R5 master reset state", int'(pgm_state_o), 0);
    chk_eq("R5 master reset ctl1", int'(ctl1_o), 0);
    chk_eq("R5 master reset ctl2", int'(ctl2_o), 0);
    chk_eq("R5 master reset latch", int'(pbuf_valid_o), 0);
  endtask

  task automatic t_timer(input logic [SEL_W-1:0] sel);
    int n = 0;
    to_load(sel);
    wr_reg(1'b1, 8'h01);
    while (hv_active_o && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
    chk_eq("R9 timed length", n, BASE_CLKS << (sel - 1));
    chk_eq("R9 timed exit state", int'(pgm_state_o), 1);
    pulse_mst();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_idle_capture();
    t_manual_pulse();
    t_timer(3'd1);
    t_timer(3'd2);
    t_timer(3'd3);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule